// File: doc/BRIEF.md
# Exception Vector Address Generator

This block decides where a processor fetches next when an exception is taken, and what it records on the way in. On a one-cycle exception strobe it samples the exception class, the status and configuration flags, the software-programmed exception base, a fixed boot base, the top two bits of the faulting address and the current PC. One clock later it presents the handler address, an updated cause register image and a write enable for the exception return PC.

The handler address is a base plus an offset. The base is the boot base when boot-time vectors are selected. A cache error may instead be steered into the uncached kernel window. Otherwise the base is the programmed base, page aligned. The offset depends on the class. For a TLB refill, the faulting region and the extended-addressing enables choose between the simple refill entry and the extended refill entry.

Top module: `exc_vector_gen`

## Requirements
- R1: Results of a strobe on `take_i` appear on the outputs after exactly one rising clock edge, and `valid_q` is high for exactly that one cycle.
- R2: When `bev_i` is set, the base is `boot_vec_i + 0x200`, whatever the class.
- R3: For a cache error with `bev_i` clear and not both `seg_ctl_i` and `cv_i` set, the base is `0xA0000000 | (ebase_i & 0x1FFFF000)`.
- R4: In every other case, the base is `ebase_i` with bits [11:0] cleared.
- R5: `class_i` encoding: 2'b00 general, 2'b01 TLB refill, 2'b10 cache error, 2'b11 handled as general. The offset is 0x180 for a general exception and 0x100 for a cache error, independent of `bev_i`. The vector is base plus offset.
- R6: A TLB refill uses offset 0x080 when (`region_i` != 0 or `ux_i`) and (`region_i` != 3 or `kx_i`), and offset 0x000 otherwise.
- R7: `epc_we_q` is set after a strobe only when `exl_i` was clear, and `epc_q` then carries the sampled `pc_i`.
- R8: `cause_q` equals `cause_i` with bits [6:2] replaced by the exception code. The code is `code_i`, except for a cache error, which always writes 30. All other bits are kept unchanged.
- R9: In a cycle without a strobe, `valid_q` and `epc_we_q` fall low, and `vec_q`, `cause_q` and `epc_q` hold their values.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Exception strobe, one cycle |
| class_i | input | 2 | Exception class |
| code_i | input | 5 | Exception code for non-cache classes |
| bev_i | input | 1 | Boot-time vectors selected |
| exl_i | input | 1 | Already at exception level |
| kx_i | input | 1 | Kernel extended addressing enabled |
| ux_i | input | 1 | User extended addressing enabled |
| region_i | input | 2 | Faulting address bits [63:62] |
| seg_ctl_i | input | 1 | Segmentation control present |
| cv_i | input | 1 | Cache-error vector override enable |
| ebase_i | input | 32 | Programmed exception base |
| boot_vec_i | input | 32 | Fixed boot exception base |
| pc_i | input | 32 | Resume PC |
| cause_i | input | 32 | Current cause register |
| valid_q | output | 1 | Result strobe |
| vec_q | output | 32 | Handler address |
| cause_q | output | 32 | Updated cause register image |
| epc_we_q | output | 1 | Return PC write enable |
| epc_q | output | 32 | Return PC value |

## Verification
All state sits in one output register stage, so a wrong captured value is visible at the ports one edge after the strobe and persists until the next strobe. A base chosen by the wrong selector appears in the upper address bits. A wrong offset or refill decision appears in bits [8:7]. A corrupted cause merge shows up either in the code field or as a flipped neighbour bit. A stuck enable shows as `epc_we_q` or `valid_q` high in an idle cycle immediately after the result cycle.

// File: rtl/exvec_pkg.sv
package exvec_pkg;
    typedef enum logic [1:0] {
        EXC_GENERAL    = 2'b00,
        EXC_TLB_REFILL = 2'b01,
        EXC_CACHE_ERR  = 2'b10,
        EXC_RSVD       = 2'b11
    } exc_class_e;

    localparam int unsigned CACHE_ERR_CODE = 30;
endpackage

// File: rtl/exvec_base.sv
module exvec_base #(
    parameter int unsigned VA_W = 32
) (
    input  logic            bev_i,
    input  logic            is_cache_i,
    input  logic            seg_ctl_i,
    input  logic            cv_i,
    input  logic [VA_W-1:0] ebase_i,
    input  logic [VA_W-1:0] boot_vec_i,
    output logic [VA_W-1:0] base_o
);
    localparam logic [VA_W-1:0] UNC_WIN   = VA_W'(32'hA000_0000);
    localparam logic [VA_W-1:0] KEEP_MASK = VA_W'(32'h1FFF_F000);
    localparam logic [VA_W-1:0] PAGE_MASK = ~VA_W'(12'hFFF);
    localparam logic [VA_W-1:0] BOOT_OFF  = VA_W'(12'h200);

    logic force_unc;

    always_comb begin
        force_unc = is_cache_i && !(seg_ctl_i && cv_i);
        if (bev_i) begin
            base_o = boot_vec_i + BOOT_OFF;
        end else if (force_unc) begin
            base_o = UNC_WIN | (ebase_i & KEEP_MASK);
        end else begin
            base_o = ebase_i & PAGE_MASK;
        end
    end
endmodule

// File: rtl/exvec_offset.sv
module exvec_offset
    import exvec_pkg::*;
#(
    parameter int unsigned VA_W = 32
) (
    input  exc_class_e      cls_i,
    input  logic [1:0]      region_i,
    input  logic            kx_i,
    input  logic            ux_i,
    output logic [VA_W-1:0] off_o
);
    localparam logic [VA_W-1:0] OFF_REFILL_X = VA_W'(12'h080);
    localparam logic [VA_W-1:0] OFF_REFILL   = VA_W'(12'h000);
    localparam logic [VA_W-1:0] OFF_CACHE    = VA_W'(12'h100);
    localparam logic [VA_W-1:0] OFF_GENERAL  = VA_W'(12'h180);

    logic use_ext;

    always_comb begin
        use_ext = (region_i != 2'd0 || ux_i) && (region_i != 2'd3 || kx_i);
        unique case (cls_i)
            EXC_TLB_REFILL: off_o = use_ext ? OFF_REFILL_X : OFF_REFILL;
            EXC_CACHE_ERR:  off_o = OFF_CACHE;
            default:        off_o = OFF_GENERAL;
        endcase
    end
endmodule

// File: rtl/exvec_cause.sv
module exvec_cause
    import exvec_pkg::*;
#(
    parameter int unsigned CAUSE_W  = 32,
    parameter int unsigned CODE_LSB = 2,
    parameter int unsigned CODE_W   = 5
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               is_cache_i,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic [CAUSE_W-1:0] FIELD_MASK =
        ((CAUSE_W'(1) << CODE_W) - CAUSE_W'(1)) << CODE_LSB;

    logic [CODE_W-1:0] code_sel;

    always_comb begin
        code_sel = is_cache_i ? CODE_W'(CACHE_ERR_CODE) : code_i;
        cause_o  = (cause_i & ~FIELD_MASK) | (CAUSE_W'(code_sel) << CODE_LSB);
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exvec_pkg::*;
#(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned CAUSE_W  = 32,
    parameter int unsigned CODE_LSB = 2,
    parameter int unsigned CODE_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [1:0]         class_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               bev_i,
    input  logic               exl_i,
    input  logic               kx_i,
    input  logic               ux_i,
    input  logic [1:0]         region_i,
    input  logic               seg_ctl_i,
    input  logic               cv_i,
    input  logic [VA_W-1:0]    ebase_i,
    input  logic [VA_W-1:0]    boot_vec_i,
    input  logic [VA_W-1:0]    pc_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic               valid_q,
    output logic [VA_W-1:0]    vec_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               epc_we_q,
    output logic [VA_W-1:0]    epc_q
);
    typedef struct packed {
        logic               valid;
        logic               epc_we;
        logic [VA_W-1:0]    vec;
        logic [VA_W-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
    } out_t;

    exc_class_e         cls;
    logic               is_cache;
    logic [VA_W-1:0]    base;
    logic [VA_W-1:0]    off;
    logic [CAUSE_W-1:0] cause_new;
    out_t               out_d;
    out_t               out_q;

    assign cls      = exc_class_e'(class_i);
    assign is_cache = (cls == EXC_CACHE_ERR);

    exvec_base #(.VA_W(VA_W)) base_i (
        .bev_i      (bev_i),
        .is_cache_i (is_cache),
        .seg_ctl_i  (seg_ctl_i),
        .cv_i       (cv_i),
        .ebase_i    (ebase_i),
        .boot_vec_i (boot_vec_i),
        .base_o     (base)
    );

    exvec_offset #(.VA_W(VA_W)) off_i (
        .cls_i    (cls),
        .region_i (region_i),
        .kx_i     (kx_i),
        .ux_i     (ux_i),
        .off_o    (off)
    );

    exvec_cause #(
        .CAUSE_W  (CAUSE_W),
        .CODE_LSB (CODE_LSB),
        .CODE_W   (CODE_W)
    ) cause_m (
        .cause_i    (cause_i),
        .code_i     (code_i),
        .is_cache_i (is_cache),
        .cause_o    (cause_new)
    );

    always_comb begin
        out_d        = out_q;
        out_d.valid  = 1'b0;
        out_d.epc_we = 1'b0;
        if (take_i) begin
            out_d.valid  = 1'b1;
            out_d.epc_we = !exl_i;
            out_d.vec    = base + off;
            out_d.cause  = cause_new;
            if (!exl_i) begin
                out_d.epc = pc_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_q  = out_q.valid;
    assign epc_we_q = out_q.epc_we;
    assign vec_q    = out_q.vec;
    assign epc_q    = out_q.epc;
    assign cause_q  = out_q.cause;
endmodule

// File: rtl/exvec_chk.sv
module exvec_chk #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned CAUSE_W  = 32,
    parameter int unsigned CODE_LSB = 2,
    parameter int unsigned CODE_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               take_i,
    input logic [1:0]         class_i,
    input logic               bev_i,
    input logic               exl_i,
    input logic               seg_ctl_i,
    input logic               cv_i,
    input logic [VA_W-1:0]    boot_vec_i,
    input logic [VA_W-1:0]    pc_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic               valid_q,
    input logic [VA_W-1:0]    vec_q,
    input logic [CAUSE_W-1:0] cause_q,
    input logic               epc_we_q,
    input logic [VA_W-1:0]    epc_q
);
    localparam logic [CAUSE_W-1:0] FIELD_MASK =
        ((CAUSE_W'(1) << CODE_W) - CAUSE_W'(1)) << CODE_LSB;

    AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> valid_q); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> (!valid_q && !epc_we_q)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(vec_q) && $stable(cause_q) && $stable(epc_q))); // R9
    AST_EPC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (epc_we_q == !$past(exl_i))); // R7
    AST_EPC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !exl_i) |=> (epc_q == $past(pc_i))); // R7
    AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (((cause_q ^ $past(cause_i)) & ~FIELD_MASK) == '0)); // R8
    AST_CACHE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && class_i == 2'b10) |=> (((cause_q & FIELD_MASK) >> CODE_LSB) == CAUSE_W'(30))); // R8
    AST_CACHE_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && class_i == 2'b10 && !bev_i && !(seg_ctl_i && cv_i))
        |=> (vec_q[31:29] == 3'b101 && vec_q[11:0] == 12'h100)); // R3
    AST_BOOT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && bev_i) |=> ((vec_q - $past(boot_vec_i)) >= VA_W'(12'h200)
                               && (vec_q - $past(boot_vec_i)) <= VA_W'(12'h380))); // R2
endmodule

bind exc_vector_gen exvec_chk #(
    .VA_W     (VA_W),
    .CAUSE_W  (CAUSE_W),
    .CODE_LSB (CODE_LSB),
    .CODE_W   (CODE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_i),
    .class_i    (class_i),
    .bev_i      (bev_i),
    .exl_i      (exl_i),
    .seg_ctl_i  (seg_ctl_i),
    .cv_i       (cv_i),
    .boot_vec_i (boot_vec_i),
    .pc_i       (pc_i),
    .cause_i    (cause_i),
    .valid_q    (valid_q),
    .vec_q      (vec_q),
    .cause_q    (cause_q),
    .epc_we_q   (epc_we_q),
    .epc_q      (epc_q)
);

// File: tb/exc_vector_gen_tb.sv
module exc_vector_gen_tb_top;
    localparam logic [31:0] BOOT     = 32'hBFC0_0000;
    localparam logic [31:0] CAUSE_IN = 32'hC3A5_5AFF;
    localparam logic [31:0] EB       = 32'h8000_1234;
    localparam logic [31:0] EBC      = 32'h8123_4567;

    typedef struct packed {
        logic [1:0]  cls;
        logic [4:0]  code;
        logic        bev;
        logic        exl;
        logic        kx;
        logic        ux;
        logic [1:0]  rgn;
        logic        sc;
        logic        cv;
        logic [31:0] ebase;
        logic [31:0] exp_vec;
        logic [4:0]  exp_code;
        logic        exp_we;
    } tv_t;

    localparam int NTV = 14;
    localparam tv_t TV [NTV] = '{
        // R4 R5 general, page-aligned base
        '{2'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EB,  32'h8000_1180, 5'd4,  1'b1},
        // R2 R7 boot base, EXL set
        '{2'd0, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EB,  32'hBFC0_0380, 5'd5,  1'b0},
        // R6 region 0, UX clear
        '{2'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EB,  32'h8000_1000, 5'd2,  1'b1},
        // R6 region 0, UX set
        '{2'd1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, EB,  32'h8000_1080, 5'd3,  1'b1},
        // R6 region 3, KX clear
        '{2'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, EB,  32'h8000_1000, 5'd2,  1'b1},
        // R6 region 3, KX set
        '{2'd1, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, EB,  32'h8000_1080, 5'd2,  1'b1},
        // R6 region 1, neither enable
        '{2'd1, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, EB,  32'h8000_1080, 5'd3,  1'b1},
        // R2 R6 region 2 with boot base
        '{2'd1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, EB,  32'hBFC0_0280, 5'd2,  1'b1},
        // R3 R8 cache error forced uncached, code forced 30
        '{2'd2, 5'd7, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EBC, 32'hA123_4100, 5'd30, 1'b1},
        // R3 SC alone does not lift forcing
        '{2'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, EBC, 32'hA123_4100, 5'd30, 1'b1},
        // R4 SC and CV both set
        '{2'd2, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, EBC, 32'h8123_4100, 5'd30, 1'b1},
        // R5 cache offset under boot base
        '{2'd2, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EBC, 32'hBFC0_0300, 5'd30, 1'b1},
        // R5 reserved class as general
        '{2'd3, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, EB,  32'h8000_1180, 5'd9,  1'b1},
        // R7 refill with EXL set
        '{2'd1, 5'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, EB,  32'h8000_1080, 5'd3,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [1:0]  class_i = '0;
    logic [4:0]  code_i = '0;
    logic        bev_i = 1'b0, exl_i = 1'b0, kx_i = 1'b0, ux_i = 1'b0;
    logic [1:0]  region_i = '0;
    logic        seg_ctl_i = 1'b0, cv_i = 1'b0;
    logic [31:0] ebase_i = '0, boot_vec_i = BOOT, pc_i = '0, cause_i = CAUSE_IN;
    logic        valid_q, epc_we_q;
    logic [31:0] vec_q, cause_q, epc_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exc_vector_gen dut_i (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .class_i(class_i),
        .code_i(code_i), .bev_i(bev_i), .exl_i(exl_i), .kx_i(kx_i),
        .ux_i(ux_i), .region_i(region_i), .seg_ctl_i(seg_ctl_i), .cv_i(cv_i),
        .ebase_i(ebase_i), .boot_vec_i(boot_vec_i), .pc_i(pc_i),
        .cause_i(cause_i), .valid_q(valid_q), .vec_q(vec_q),
        .cause_q(cause_q), .epc_we_q(epc_we_q), .epc_q(epc_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_cause(input logic [4:0] c);
        return (CAUSE_IN & ~32'h0000_007C) | ({27'd0, c} << 2);
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_vec;
        repeat (3) @(negedge clk);
        chk("R10 valid", {31'd0, valid_q}, 32'd0);
        chk("R10 vec", vec_q, 32'd0);
        chk("R10 cause", cause_q, 32'd0);
        chk("R10 epc_we", {31'd0, epc_we_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NTV; i++) begin
            class_i   = TV[i].cls;
            code_i    = TV[i].code;
            bev_i     = TV[i].bev;
            exl_i     = TV[i].exl;
            kx_i      = TV[i].kx;
            ux_i      = TV[i].ux;
            region_i  = TV[i].rgn;
            seg_ctl_i = TV[i].sc;
            cv_i      = TV[i].cv;
            ebase_i   = TV[i].ebase;
            pc_i      = 32'h0040_0000 + 32'(i) * 4;
            take_i    = 1'b1;
            @(negedge clk);
            take_i = 1'b0;
            chk($sformatf("R1 valid tv%0d", i), {31'd0, valid_q}, 32'd1);
            chk($sformatf("R2-R6 vec tv%0d", i), vec_q, TV[i].exp_vec);
            chk($sformatf("R8 cause tv%0d", i), cause_q, merge_cause(TV[i].exp_code));
            chk($sformatf("R7 epc_we tv%0d", i), {31'd0, epc_we_q}, {31'd0, TV[i].exp_we});
            if (TV[i].exp_we) chk($sformatf("R7 epc tv%0d", i), epc_q, pc_i);
            @(negedge clk);
            chk($sformatf("R9 valid low tv%0d", i), {31'd0, valid_q}, 32'd0);
        end

        // R1: output does not change before the clock edge
        class_i = 2'd0; code_i = 5'd12; bev_i = 1'b0; exl_i = 1'b0;
        ebase_i = 32'h9000_0000; pc_i = 32'h0000_1234;
        take_i = 1'b1;
        #1;
        chk("R1 no early valid", {31'd0, valid_q}, 32'd0);
        @(negedge clk);
        take_i = 1'b0;
        chk("R1 vec after edge", vec_q, 32'h9000_0180);
        held_vec = vec_q;

        // R9: idle cycles with changed inputs leave results held
        ebase_i = 32'h1111_1000; cause_i = 32'h0; pc_i = 32'hDEAD_0000; exl_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 vec held", vec_q, held_vec);
        chk("R9 cause held", cause_q, merge_cause(5'd12));
        chk("R9 epc held", epc_q, 32'h0000_1234);
        chk("R9 epc_we low", {31'd0, epc_we_q}, 32'd0);

        // R7: EXL set keeps previous epc value
        exl_i = 1'b1; cause_i = CAUSE_IN; take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
        chk("R7 epc kept under EXL", epc_q, 32'h0000_1234);

        // R10: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        chk("R10 async clear vec", vec_q, 32'd0);
        chk("R10 async clear epc", epc_q, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule